// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block is the bus-master engine of a four-channel DMA controller. Once arbitration has picked a channel, a one-cycle `start` pulse hands the engine that channel's number, its cycle type, its mode options and its current address and remaining count. The engine then steps through a fixed four-state bus cycle, one state per clock: address out (S1), strobes on (S2), hold (S3, repeated while the synchronised READY is low) and finish (S4). The low address byte appears on its own port. The high byte is placed on the shared data lines for one state and marked by an address strobe, so an external latch can capture it.

The cycle type selects the strobe pair. A read cycle moves memory to the peripheral, a write cycle moves the peripheral to memory, and a verify cycle only walks the address and count. In S4 the engine presents the channel's updated address and count on a write-back port. It flags terminal count and every 128-byte boundary, and it asks the register file to drop the channel's enable when stop-on-TC is set. On the reload channel with auto-load set, it returns the reload values in place of the stepped ones and raises an update flag.

Top module: `dma_cycle_seq`

## Requirements
- R1: While reset is high and after it is released, `aen`, `adstb`, `db_oe`, `tc`, `mark`, `wb_valid`, `en_clr` and `upd_flag` are low and all four active-low strobes are high.
- R2: A `start` pulse in idle moves the engine to S1 on the next clock. In S1 `aen`, `adstb` and `db_oe` are high, `db_out` carries `cur_addr[15:8]` and `addr_lo` carries `cur_addr[7:0]`. `aen` stays high through S4 and is low again in the state after S4.
- R3: `cyc_type` 2'b10 is a read cycle. `mem_rd_n` is low in S2 and S3, `io_wr_n` is low in S3, and `mem_wr_n` and `io_rd_n` stay high.
- R4: `cyc_type` 2'b01 is a write cycle. `io_rd_n` is low in S2 and S3, `mem_wr_n` is low in S3, and `mem_rd_n` and `io_wr_n` stay high.
- R5: `cyc_type` 2'b00 is a verify cycle. All four strobes stay high, yet the address and count are still stepped in S4.
- R6: With `ext_write` high, the write strobe of a read or write cycle is already low in S2.
- R7: `ready` passes through a two-stage synchroniser. While its synchronised value is low the engine stays in S3 with its strobes held. After `ready` rises, two more clocks pass in S3 and the third clock enters S4.
- R8: In S4 `wb_valid` is high for one clock. `wb_chan` is the started channel, `wb_addr` is the address plus one (mod 2^16) and `wb_count` is the count minus one (mod 2^14).
- R9: `tc` is high from S1 through S4 when the latched count is zero.
- R10: `mark` is high from S1 through S4 when the low seven bits of the latched count are zero.
- R11: At terminal count with `stop_on_tc` high, `en_clr` is high together with `wb_valid`, unless an auto-load reload happens in that cycle.
- R12: At terminal count on channel 2 with `auto_load` high, `wb_addr` and `wb_count` equal `reload_addr` and `reload_count`, `upd_flag` is high with `wb_valid`, and `en_clr` stays low. Auto-load has no effect on other channels.
- R13: `start` and the channel inputs are ignored while a cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one cycle for the granted channel |
| chan | input | 2 | Granted channel number |
| cyc_type | input | 2 | 00 verify, 01 write, 10 read |
| ext_write | input | 1 | Early write strobe option |
| stop_on_tc | input | 1 | Drop channel enable at terminal count |
| auto_load | input | 1 | Reload channel 2 at terminal count |
| cur_addr | input | 16 | Channel's current address |
| cur_count | input | 14 | Channel's remaining count (bytes minus one) |
| reload_addr | input | 16 | Address that auto-load restores |
| reload_count | input | 14 | Count that auto-load restores |
| ready | input | 1 | Asynchronous wait control, low inserts waits |
| aen | output | 1 | Engine owns the bus |
| adstb | output | 1 | High address byte valid on db_out |
| db_out | output | 8 | High address byte during S1 |
| db_oe | output | 1 | Drive enable for db_out |
| addr_lo | output | 8 | Low address byte |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | Peripheral read strobe, active low |
| io_wr_n | output | 1 | Peripheral write strobe, active low |
| tc | output | 1 | Terminal-count cycle |
| mark | output | 1 | 128-byte boundary cycle |
| wb_valid | output | 1 | Write-back of address and count |
| wb_chan | output | 2 | Channel being written back |
| wb_addr | output | 16 | New channel address |
| wb_count | output | 14 | New channel count |
| en_clr | output | 1 | Clear this channel's enable |
| upd_flag | output | 1 | Auto-load reload in progress |

## Verification
The hardest situation to reach from the ports is a long wait in S3. READY goes through a synchroniser, so the bench drives it low several clocks before `start`, holds the engine in S3 across several clocks while it checks the held strobes, and then counts the exact clocks from the rise of READY to S4. Terminal count on the reload channel is the other corner. The vector table covers it with auto-load together with stop-on-TC, and also with auto-load on a channel that does not reload, where it must have no effect.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int CNT_W  = 14;
    localparam int CH_W   = 2;
    localparam int BYTE_W = 8;
    localparam int MARK_W = 7;   // boundary every 2**MARK_W bytes

    typedef enum logic [1:0] {
        CYC_VERIFY = 2'b00,
        CYC_WRITE  = 2'b01,
        CYC_READ   = 2'b10
    } cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_S1,
        ST_S2,
        ST_S3,
        ST_S4
    } seq_state_e;

    // Snapshot of the granted channel, taken on start
    typedef struct packed {
        logic [CH_W-1:0]   chan;
        cyc_e              cyc;
        logic              ext;
        logic              stop;
        logic              autold;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] raddr;
        logic [CNT_W-1:0]  rcnt;
    } ctx_t;

    function automatic logic on_boundary(input logic [CNT_W-1:0] c);
        return c[MARK_W-1:0] == '0;
    endfunction

endpackage

// File: rtl/dma_ready_sync.sv
module dma_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ready_async,
    output logic ready_s
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= ready_async;
            end
            assign ready_s = q;
        end else begin : g_chain
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[STAGES-2:0], ready_async};
            end
            assign ready_s = sr[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       ready_s,
    output seq_state_e state
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_S1;
            ST_S1:   nxt = ST_S2;
            ST_S2:   nxt = ST_S3;
            ST_S3:   if (ready_s) nxt = ST_S4;
            ST_S4:   nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R7: a low synchronised ready holds the hold state
    a_r7_wait_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_S3 && !ready_s) |=> (state == ST_S3));

    // R2: the finish state always returns to idle
    a_r2_s4_to_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_S4) |=> (state == ST_IDLE));

endmodule

// File: rtl/dma_strobe_gen.sv
module dma_strobe_gen
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state,
    input  cyc_e       cyc,
    input  logic       ext,
    output logic       mem_rd_n,
    output logic       mem_wr_n,
    output logic       io_rd_n,
    output logic       io_wr_n
);
    logic rd_phase, wr_phase;

    assign rd_phase = (state == ST_S2) || (state == ST_S3);
    assign wr_phase = (state == ST_S3) || (ext && state == ST_S2);

    assign mem_rd_n = !(cyc == CYC_READ  && rd_phase);
    assign io_wr_n  = !(cyc == CYC_READ  && wr_phase);
    assign io_rd_n  = !(cyc == CYC_WRITE && rd_phase);
    assign mem_wr_n = !(cyc == CYC_WRITE && wr_phase);

    // R3/R4: the read-cycle pair and the write-cycle pair never overlap
    a_r3_pairs_exclusive: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_n || !io_wr_n) |-> (mem_wr_n && io_rd_n));

    // R6: a write strobe only ever sits inside its read strobe window
    a_r6_wr_inside_rd: assert property (@(posedge clk) disable iff (rst)
        (!io_wr_n |-> !mem_rd_n) and (!mem_wr_n |-> !io_rd_n));

endmodule

// File: rtl/dma_count_upd.sv
module dma_count_upd
    import dma_seq_pkg::*;
#(
    parameter int AUTO_CH = 2
) (
    input  logic [CH_W-1:0]   chan,
    input  logic              stop,
    input  logic              autold,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [CNT_W-1:0]  rcnt,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [CNT_W-1:0]  nxt_cnt,
    output logic              at_tc,
    output logic              at_mark,
    output logic              do_reload,
    output logic              do_clr
);
    localparam logic [CH_W-1:0] RELOAD_CH = CH_W'(AUTO_CH);

    assign at_tc     = (cnt == '0);
    assign at_mark   = on_boundary(cnt);
    assign do_reload = autold && at_tc && (chan == RELOAD_CH);
    assign do_clr    = stop && at_tc && !do_reload;
    assign nxt_addr  = do_reload ? raddr : addr + ADDR_W'(1);
    assign nxt_cnt   = do_reload ? rcnt  : cnt - CNT_W'(1);
endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
    import dma_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int AUTO_CH     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CH_W-1:0]   chan,
    input  logic [1:0]        cyc_type,
    input  logic              ext_write,
    input  logic              stop_on_tc,
    input  logic              auto_load,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  cur_count,
    input  logic [ADDR_W-1:0] reload_addr,
    input  logic [CNT_W-1:0]  reload_count,
    input  logic              ready,
    output logic              aen,
    output logic              adstb,
    output logic [BYTE_W-1:0] db_out,
    output logic              db_oe,
    output logic [BYTE_W-1:0] addr_lo,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic              tc,
    output logic              mark,
    output logic              wb_valid,
    output logic [CH_W-1:0]   wb_chan,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [CNT_W-1:0]  wb_count,
    output logic              en_clr,
    output logic              upd_flag
);
    seq_state_e state;
    ctx_t       ctx;
    logic       ready_s;
    logic       at_tc, at_mark, do_reload, do_clr;

    dma_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ready_async(ready), .ready_s(ready_s));

    dma_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .ready_s(ready_s), .state(state));

    // Snapshot taken only in idle, so inputs are ignored mid-cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '0;
        end else if (state == ST_IDLE && start) begin
            ctx.chan   <= chan;
            ctx.cyc    <= cyc_e'(cyc_type);
            ctx.ext    <= ext_write;
            ctx.stop   <= stop_on_tc;
            ctx.autold <= auto_load;
            ctx.addr   <= cur_addr;
            ctx.cnt    <= cur_count;
            ctx.raddr  <= reload_addr;
            ctx.rcnt   <= reload_count;
        end
    end

    dma_strobe_gen u_strb (
        .clk(clk), .rst(rst), .state(state), .cyc(ctx.cyc), .ext(ctx.ext),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n));

    dma_count_upd #(.AUTO_CH(AUTO_CH)) u_upd (
        .chan(ctx.chan), .stop(ctx.stop), .autold(ctx.autold),
        .addr(ctx.addr), .cnt(ctx.cnt), .raddr(ctx.raddr), .rcnt(ctx.rcnt),
        .nxt_addr(wb_addr), .nxt_cnt(wb_count), .at_tc(at_tc),
        .at_mark(at_mark), .do_reload(do_reload), .do_clr(do_clr));

    assign aen      = (state != ST_IDLE);
    assign adstb    = (state == ST_S1);
    assign db_oe    = (state == ST_S1);
    assign db_out   = db_oe ? ctx.addr[ADDR_W-1 -: BYTE_W] : '0;
    assign addr_lo  = aen ? ctx.addr[BYTE_W-1:0] : '0;
    assign tc       = aen && at_tc;
    assign mark     = aen && at_mark;
    assign wb_valid = (state == ST_S4);
    assign wb_chan  = ctx.chan;
    assign en_clr   = wb_valid && do_clr;
    assign upd_flag = wb_valid && do_reload;

    // R2: the address strobe only appears while the bus is owned
    a_r2_adstb_in_aen: assert property (@(posedge clk) disable iff (rst)
        adstb |-> aen);

    // R11: enable clear only on a terminal-count write-back
    a_r11_clr_at_tc: assert property (@(posedge clk) disable iff (rst)
        en_clr |-> (tc && wb_valid));

    // R12: a reload never also clears the enable
    a_r12_reload_keeps_en: assert property (@(posedge clk) disable iff (rst)
        upd_flag |-> (tc && !en_clr));

    // R8: write-back is a single clock followed by bus release
    a_r8_wb_single: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> (!wb_valid && !aen));

endmodule

// File: tb/tb_dma_cycle_seq.sv
module tb_dma_cycle_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  chan;
    logic [1:0]  cyc_type;
    logic        ext_write, stop_on_tc, auto_load;
    logic [15:0] cur_addr, reload_addr;
    logic [13:0] cur_count, reload_count;
    logic        ready;
    logic        aen, adstb, db_oe, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
    logic [7:0]  db_out, addr_lo;
    logic        tc, mark, wb_valid, en_clr, upd_flag;
    logic [1:0]  wb_chan;
    logic [15:0] wb_addr;
    logic [13:0] wb_count;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dma_cycle_seq dut (
        .clk(clk), .rst(rst), .start(start), .chan(chan), .cyc_type(cyc_type),
        .ext_write(ext_write), .stop_on_tc(stop_on_tc), .auto_load(auto_load),
        .cur_addr(cur_addr), .cur_count(cur_count), .reload_addr(reload_addr),
        .reload_count(reload_count), .ready(ready), .aen(aen), .adstb(adstb),
        .db_out(db_out), .db_oe(db_oe), .addr_lo(addr_lo), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .tc(tc),
        .mark(mark), .wb_valid(wb_valid), .wb_chan(wb_chan), .wb_addr(wb_addr),
        .wb_count(wb_count), .en_clr(en_clr), .upd_flag(upd_flag));

    typedef struct packed {
        logic [1:0]  cyc;
        logic        ext;
        logic [1:0]  ch;
        logic        stop;
        logic        autold;
        logic [15:0] addr;
        logic [13:0] cnt;
        logic [15:0] raddr;
        logic [13:0] rcnt;
        logic [15:0] eaddr;
        logic [13:0] ecnt;
        logic        etc;
        logic        emark;
        logic        eclr;
        logic        eupd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{2'b10, 1'b0, 2'd0, 1'b0, 1'b0, 16'h12FF, 14'd5,   16'h0000, 14'd0,
          16'h1300, 14'd4,      1'b0, 1'b0, 1'b0, 1'b0},
        '{2'b01, 1'b0, 2'd1, 1'b1, 1'b0, 16'hFFFF, 14'd0,   16'h0000, 14'd0,
          16'h0000, 14'h3FFF,   1'b1, 1'b1, 1'b1, 1'b0},
        '{2'b00, 1'b0, 2'd3, 1'b0, 1'b0, 16'h4000, 14'd128, 16'h0000, 14'd0,
          16'h4001, 14'd127,    1'b0, 1'b1, 1'b0, 1'b0},
        '{2'b01, 1'b1, 2'd2, 1'b0, 1'b0, 16'h00A0, 14'h0010, 16'h0000, 14'd0,
          16'h00A1, 14'h000F,   1'b0, 1'b0, 1'b0, 1'b0},
        '{2'b10, 1'b0, 2'd2, 1'b1, 1'b1, 16'h2222, 14'd0,   16'h8000, 14'h0123,
          16'h8000, 14'h0123,   1'b1, 1'b1, 1'b0, 1'b1},
        '{2'b10, 1'b1, 2'd3, 1'b0, 1'b1, 16'h0100, 14'd0,   16'h9999, 14'h0042,
          16'h0101, 14'h3FFF,   1'b1, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected strobes {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} for a state (2 or 3)
    function automatic logic [3:0] exp_strb(input logic [1:0] cyc, input logic ext, input int st);
        logic rd, wr;
        rd = (st == 2) || (st == 3);
        wr = (st == 3) || (ext && st == 2);
        if (cyc == 2'b10) return {~rd, 1'b1, 1'b1, ~wr};   // R3 read
        if (cyc == 2'b01) return {1'b1, ~wr, ~rd, 1'b1};   // R4 write
        return 4'b1111;                                    // R5 verify
    endfunction

    function automatic string strb_req(input logic [1:0] cyc, input logic ext);
        if (ext && cyc != 2'b00) return "R6 ext-write strobes";
        if (cyc == 2'b10) return "R3 read strobes";
        if (cyc == 2'b01) return "R4 write strobes";
        return "R5 verify strobes";
    endfunction

    task automatic drive(input vec_t v);
        chan = v.ch; cyc_type = v.cyc; ext_write = v.ext; stop_on_tc = v.stop;
        auto_load = v.autold; cur_addr = v.addr; cur_count = v.cnt;
        reload_addr = v.raddr; reload_count = v.rcnt;
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        drive(v);
        start = 1'b1;
        @(posedge clk); #1;
        check("R2 aen in S1", aen, 1);
        check("R2 adstb in S1", adstb, 1);
        check("R2 db_oe in S1", db_oe, 1);
        check("R2 high byte", db_out, v.addr[15:8]);
        check("R2 low byte", addr_lo, v.addr[7:0]);
        check("R9 tc", tc, v.etc);
        check("R10 mark", mark, v.emark);
        @(negedge clk);
        start = 1'b0;
        @(posedge clk); #1;
        check("R2 adstb off in S2", {adstb, db_oe}, 0);
        check(strb_req(v.cyc, v.ext), {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n},
              exp_strb(v.cyc, v.ext, 2));
        @(posedge clk); #1;
        check(strb_req(v.cyc, v.ext), {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n},
              exp_strb(v.cyc, v.ext, 3));
        check("R9 tc held", tc, v.etc);
        @(posedge clk); #1;
        check("R8 wb_valid", wb_valid, 1);
        check("R8 wb_chan", wb_chan, v.ch);
        check(v.eupd ? "R12 reload addr" : (v.cyc == 2'b00 ? "R5 verify addr" : "R8 addr"),
              wb_addr, v.eaddr);
        check(v.eupd ? "R12 reload count" : "R8 count", wb_count, v.ecnt);
        check("R11 en_clr", en_clr, v.eclr);
        check("R12 upd_flag", upd_flag, v.eupd);
        check("R2 strobes off in S4", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'b1111);
        @(posedge clk); #1;
        check("R2 aen released", aen, 0);
        check("R8 wb single clock", wb_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; ready = 1'b1;
        drive(VEC[0]);
        @(posedge clk); #1;
        check("R1 aen in reset", aen, 0);
        check("R1 strobes in reset", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'b1111);
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        repeat (4) @(posedge clk); #1;
        check("R1 idle outputs", {aen, adstb, db_oe, tc, mark, wb_valid, en_clr, upd_flag}, 0);
        check("R1 idle strobes", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'b1111);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R13: start and channel inputs ignored mid-cycle
        @(negedge clk);
        drive(VEC[0]); start = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); start = 1'b0;
        @(posedge clk); #1;                           // S2
        @(negedge clk);
        start = 1'b1; chan = 2'd3; cur_addr = 16'h5555; cur_count = 14'd0;
        @(posedge clk); #1;                           // S3
        check("R13 tc unaffected", tc, 0);
        @(negedge clk); start = 1'b0;
        @(posedge clk); #1;                           // S4
        check("R13 wb_chan kept", wb_chan, 2'd0);
        check("R13 wb_addr kept", wb_addr, 16'h1300);
        @(posedge clk); #1;
        check("R13 no extra cycle", aen, 0);
        @(posedge clk); #1;
        check("R13 still idle", aen, 0);

        // R7: wait states from a low ready
        @(negedge clk); ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        drive(VEC[0]); start = 1'b1;
        @(posedge clk); #1;                           // S1
        @(negedge clk); start = 1'b0;
        @(posedge clk); #1;                           // S2
        @(posedge clk); #1;                           // S3
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            check("R7 held in S3", {wb_valid, mem_rd_n, io_wr_n}, 3'b000);
        end
        @(negedge clk); ready = 1'b1;
        @(posedge clk); #1;
        check("R7 sync stage 1", wb_valid, 0);
        @(posedge clk); #1;
        check("R7 sync stage 2", wb_valid, 0);
        @(posedge clk); #1;
        check("R7 S4 after wait", wb_valid, 1);
        check("R7 addr after wait", wb_addr, 16'h1300);
        @(posedge clk); #1;
        check("R7 released", aen, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule